// File: doc/BRIEF.md
# Staged Power Switch Ramp Controller

This block drives the 8-bit enable code of the head switch that feeds one core power domain. A code of 0xFF holds the switch fully closed, so the domain is unpowered. A code of 0x00 holds it fully open, so the domain is powered. The switch is opened in stages to limit in-rush current. The block walks a fixed, non-linear list of partial codes and holds each code for a fixed dwell before it moves on. Closing the switch takes a single step.

Power management logic issues single-cycle on or off requests. The block raises `busy` for as long as a sequence runs. It pulses `done` for one cycle when the final dwell ends. While `busy` is high, new requests are dropped. An on request that arrives when the switch is already fully open finishes at once and runs no stages. The dwell length is given in microseconds, and the clock-cycles-per-microsecond count is a parameter.

Top module: `swramp_top`

## Requirements
- R1: After reset, `sw_code` is 0xFF, `busy` is 0 and `done` is 0.
- R2: An on request taken while idle, with `sw_code` not equal to 0x00, drives `sw_code` through 0xFF, 0xFE, 0xF8, 0xF0 and then 0x00, in that order. The first code appears in the cycle after the request.
- R3: Each code of a sequence is held for exactly DWELL_US*CLK_PER_US clock cycles, and `busy` stays 1 throughout.
- R4: `done` is high for exactly one cycle, in the cycle right after the last dwell ends. `busy` is 0 in that same cycle.
- R5: An on request taken while idle with `sw_code` already 0x00 leaves `sw_code` at 0x00. It keeps `busy` at 0 and raises `done` in the next cycle.
- R6: An off request taken while idle drives `sw_code` to 0xFF in the next cycle. It holds `busy` for one dwell and then pulses `done`.
- R7: On and off requests that arrive while `busy` is 1 are ignored. The running sequence continues unchanged.
- R8: If on and off requests arrive in the same idle cycle, the off request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_req | input | 1 | Request to open the switch (power on) |
| off_req | input | 1 | Request to close the switch (power off) |
| sw_code | output | 8 | Head-switch enable code; 0xFF closed, 0x00 open |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with CLK_PER_US = 2 and DWELL_US = 10, which gives a 20-cycle dwell. At that length the bench can check every cycle of a full five-stage ramp, and both edges of every dwell window, in a short run. The short window also leaves room to inject requests in the middle of a ramp or a close, to take an on request while the switch is already open, and to raise both requests in one cycle.

// File: rtl/swramp_pkg.sv
package swramp_pkg;
    localparam int CODE_W  = 8;
    localparam int N_STEPS = 5;
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    typedef logic [CODE_W-1:0] sw_code_t;

    localparam sw_code_t CODE_CLOSED = 8'hFF;
    localparam sw_code_t CODE_OPEN   = 8'h00;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_RAMP,
        MODE_CLOSE
    } mode_e;
endpackage

// File: rtl/swramp_steps.sv
module swramp_steps
    import swramp_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output sw_code_t          code
);
    // Fixed opening sequence; any index past the end maps to fully open.
    always_comb begin
        case (idx)
            STEP_W'(0): code = 8'hFF;
            STEP_W'(1): code = 8'hFE;
            STEP_W'(2): code = 8'hF8;
            STEP_W'(3): code = 8'hF0;
            default:    code = CODE_OPEN;
        endcase
    end
endmodule

// File: rtl/swramp_dwell.sv
module swramp_dwell #(
    parameter int CLK_PER_US = 100,
    parameter int DWELL_US   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int DWELL_CYC = DWELL_US * CLK_PER_US;
    localparam int CNT_W     = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_CYC - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD_VAL;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R3: the count never leaves the dwell window
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt <= LOAD_VAL));

    // R3: a running count steps down by one per cycle
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && tmr_q.cnt != '0 && !load) |=>
            (tmr_q.run && tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));
endmodule

// File: rtl/swramp_top.sv
module swramp_top
    import swramp_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int DWELL_US   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req,
    input  logic       off_req,
    output logic [7:0] sw_code,
    output logic       busy,
    output logic       done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        mode_e             mode;
        logic [STEP_W-1:0] step;
        sw_code_t          code;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tmr_load;
    logic              tmr_expire;
    logic [STEP_W-1:0] seq_idx;
    sw_code_t          seq_code;

    assign seq_idx = (ctl_q.mode == MODE_IDLE) ? '0 : (ctl_q.step + STEP_W'(1));

    swramp_steps u_steps (
        .idx  (seq_idx),
        .code (seq_code)
    );

    swramp_dwell #(
        .CLK_PER_US (CLK_PER_US),
        .DWELL_US   (DWELL_US)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expire (tmr_expire)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        case (ctl_q.mode)
            MODE_IDLE: begin
                if (off_req) begin
                    ctl_d.mode = MODE_CLOSE;
                    ctl_d.code = CODE_CLOSED;
                    tmr_load   = 1'b1;
                end else if (on_req) begin
                    if (ctl_q.code == CODE_OPEN) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.mode = MODE_RAMP;
                        ctl_d.step = '0;
                        ctl_d.code = seq_code;
                        tmr_load   = 1'b1;
                    end
                end
            end
            MODE_RAMP: begin
                if (tmr_expire) begin
                    if (ctl_q.step == LAST_STEP) begin
                        ctl_d.mode = MODE_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.step = ctl_q.step + STEP_W'(1);
                        ctl_d.code = seq_code;
                        tmr_load   = 1'b1;
                    end
                end
            end
            MODE_CLOSE: begin
                if (tmr_expire) begin
                    ctl_d.mode = MODE_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode <= MODE_IDLE;
            ctl_q.step <= '0;
            ctl_q.code <= CODE_CLOSED;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sw_code = ctl_q.code;
    assign busy    = (ctl_q.mode != MODE_IDLE);
    assign done    = ctl_q.done;

    // R4: done never lasts two cycles
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done coincides with an idle block
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: only codes of the opening list ever appear
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code == 8'hFF || sw_code == 8'hFE || sw_code == 8'hF8 ||
         sw_code == 8'hF0 || sw_code == 8'h00));

    // R7: between dwell expiries a busy block holds its code and stays busy
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_expire) |=> ($stable(sw_code) && busy));

    // R5: an on request with the switch already open finishes at once
    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && on_req && !off_req && sw_code == CODE_OPEN) |=>
            (done && !busy && sw_code == CODE_OPEN));

    // R6 / R8: an idle off request closes the switch next cycle
    p_off_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && off_req) |=> (busy && sw_code == CODE_CLOSED));
endmodule

// File: tb/test_swramp_top.sv
module test_swramp_top;
    localparam int CPU = 2;
    localparam int DUS = 10;
    localparam int D   = CPU * DUS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       on_req = 1'b0;
    logic       off_req = 1'b0;
    logic [7:0] sw_code;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    swramp_top #(.CLK_PER_US(CPU), .DWELL_US(DUS)) i_swramp_top (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .sw_code(sw_code), .busy(busy), .done(done)
    );

    function automatic logic [7:0] ramp_code(input int s);
        case (s)
            0: return 8'hFF;
            1: return 8'hFE;
            2: return 8'hF8;
            3: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 200000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // Drive a one-cycle request; returns at the negedge after the sampling edge.
    task automatic pulse(input logic on_v, input logic off_v);
        @(negedge clk);
        on_req  = on_v;
        off_req = off_v;
        @(negedge clk);
        on_req  = 1'b0;
        off_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(sw_code == 8'hFF, "R1 code", sw_code, 8'hFF);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
    endtask

    // Full ramp; optionally pokes requests mid-ramp (R7).
    task automatic t_ramp(input logic poke, input logic both);
        int bad [5];
        for (int s = 0; s < 5; s++) bad[s] = 0;
        pulse(1'b1, both);
        for (int k = 0; k < 5 * D; k++) begin
            if (sw_code != ramp_code(k / D) || !busy || done) bad[k / D]++;
            if (poke && (k == D + 3 || k == 3 * D - 1)) begin
                on_req  = 1'b1;
                off_req = 1'b1;
            end else begin
                on_req  = 1'b0;
                off_req = 1'b0;
            end
            @(negedge clk);
        end
        on_req  = 1'b0;
        off_req = 1'b0;
        for (int s = 0; s < 5; s++)
            chk(bad[s] == 0, poke ? "R7 ramp step" : "R2/R3 ramp step", bad[s], 0);
        chk(done && !busy && sw_code == 8'h00, "R4 done at end",
            {done, busy, sw_code}, {1'b1, 1'b0, 8'h00});
        @(negedge clk);
        chk(!done && !busy, "R4 done one cycle", {done, busy}, 0);
    endtask

    task automatic t_skip();
        pulse(1'b1, 1'b0);
        chk(done && !busy && sw_code == 8'h00, "R5 skip",
            {done, busy, sw_code}, {1'b1, 1'b0, 8'h00});
        @(negedge clk);
        chk(!done && sw_code == 8'h00, "R5 after skip", {done, sw_code}, 0);
    endtask

    // Close; optionally with both requests together (R8) and a mid-close on poke (R7).
    task automatic t_close(input logic both, input logic poke);
        int bad = 0;
        pulse(both, 1'b1);
        for (int k = 0; k < D; k++) begin
            if (sw_code != 8'hFF || !busy || done) bad++;
            on_req = poke && (k == D / 2);
            @(negedge clk);
        end
        on_req = 1'b0;
        chk(bad == 0, both ? "R8 off wins" : (poke ? "R7 close ignore" : "R6 close hold"), bad, 0);
        chk(done && !busy && sw_code == 8'hFF, "R6 close done",
            {done, busy, sw_code}, {1'b1, 1'b0, 8'hFF});
        @(negedge clk);
        chk(!done, "R4 close done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp(1'b0, 1'b0);
        t_skip();
        t_close(1'b0, 1'b0);
        t_ramp(1'b1, 1'b0);
        t_close(1'b1, 1'b0);
        t_ramp(1'b0, 1'b0);
        t_close(1'b0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule